// File: doc/BRIEF.md
# TDM Slot-Mapped Serial Audio Port

This block is a master-mode serial audio port. It moves 16-bit stereo samples through a frame made of fixed-width time slots. A bit-clock enable from the surrounding logic paces it. From that enable the block makes a serial clock, a left/right frame sync and the transmit data line, and it samples the receive data line.

Four channels carry audio: left transmit, right transmit, left receive and right receive. Each channel has its own enable and its own 4-bit slot number. Transmit and receive can therefore share a slot or use separate slots, and frames of two, four or more slots are possible.

On the host side, each transmit channel has a one-deep holding register with a ready/valid handshake. Each receive channel presents its sample together with a one-cycle valid pulse.

Top module: `tdm_audio_port`

## Requirements
- R1: While reset is held and after its release, before the first bit-clock enable, `sck`, `sync` and `txd` are low, both `tx_*_ready` are high, and no `rx_*_valid` or `tx_*_underrun` is asserted.
- R2: `sck` toggles once for every `bit_en` cycle. With `cfg_rx_rise`=1, `rxd` is sampled when `sck` rises, and `txd`/`sync` change only when `sck` falls. With `cfg_rx_rise`=0 the two edges swap. `txd` and `sync` never change between launch edges.
- R3: A frame holds `cfg_frame_slots_m1`+1 slots of 16 bits, and that slot count is even (2 to 16). `sync` is high for the slots in the first half of the frame and low for the rest. The first bit of slot 0 goes out in the same bit period in which `sync` rises.
- R4: Transmit samples go out most significant bit first, in the slot named by the channel's slot number. Every bit of a slot that no enabled transmit channel owns is 0.
- R5: A transmit holding register accepts a word when `valid` and `ready` are both high, and `ready` then drops. At the first bit of the owning slot the word moves into the shifter and `ready` rises again.
- R6: If an enabled transmit channel's holding register is empty at the start of its slot, the slot carries all zeros and the channel's `underrun` output is high for exactly one clock.
- R7: Each enabled receive channel assembles the 16 bits of its slot with the first bit received as the MSB. After the last bit is sampled, the channel presents the word with `valid` high for one clock. Both receive channels may name the same slot.
- R8: A disabled channel has no effect at the ports. A disabled transmit channel never takes its held word and never reports underrun, and a disabled receive channel never raises `valid`.
- R9: When both transmit channels name the same slot, the left channel drives it. The right channel's held word stays in its holding register (`ready` stays low), and no underrun is reported for it.
- R10: The four slot numbers are independent. A four-slot frame with left transmit in slot 0, left receive in slot 1, right transmit in slot 2 and right receive in slot 3 sends and receives each word in its own slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Half-bit-period strobe; each pulse toggles `sck` |
| cfg_rx_rise | input | 1 | 1: sample `rxd` on rising `sck`; 0: on falling |
| cfg_frame_slots_m1 | input | 4 | Number of slots per frame minus one (odd value) |
| tx_l_en | input | 1 | Left transmit channel enable |
| tx_l_slot | input | 4 | Left transmit slot number |
| tx_r_en | input | 1 | Right transmit channel enable |
| tx_r_slot | input | 4 | Right transmit slot number |
| rx_l_en | input | 1 | Left receive channel enable |
| rx_l_slot | input | 4 | Left receive slot number |
| rx_r_en | input | 1 | Right receive channel enable |
| rx_r_slot | input | 4 | Right receive slot number |
| tx_l_data | input | 16 | Left transmit sample |
| tx_l_valid | input | 1 | Left transmit sample offered |
| tx_l_ready | output | 1 | Left holding register empty |
| tx_r_data | input | 16 | Right transmit sample |
| tx_r_valid | input | 1 | Right transmit sample offered |
| tx_r_ready | output | 1 | Right holding register empty |
| rxd | input | 1 | Serial receive data |
| tx_l_underrun | output | 1 | One-clock pulse: left slot started with no sample |
| tx_r_underrun | output | 1 | One-clock pulse: right slot started with no sample |
| rx_l_data | output | 16 | Last left receive sample |
| rx_l_valid | output | 1 | One-clock pulse: new left sample |
| rx_r_data | output | 16 | Last right receive sample |
| rx_r_valid | output | 1 | One-clock pulse: new right sample |
| sck | output | 1 | Serial clock |
| sync | output | 1 | Frame sync, high in the left half of the frame |
| txd | output | 1 | Serial transmit data |

## Verification
The hardest case to reach is the one where both transmit channels claim the same slot. Here the lower-priority channel must keep its word across a whole frame without reporting underrun. The stimulus loads both holding registers before the bit clock starts, points both channels at slot 0 and then watches `tx_r_ready` and the underrun pulses for a complete frame. Edge selection is checked through the data itself. The bench changes `rxd` only right after a launch edge, so a design that samples on the wrong edge captures the previous bit and corrupts the received words.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  // Transmit and receive channel indices
  localparam int CH_L = 0;
  localparam int CH_R = 1;
  localparam int NUM_CH = 2;
endpackage

// File: rtl/tdm_sck_gen.sv
module tdm_sck_gen (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic rx_rise,
  output logic sck,
  output logic launch,
  output logic sample
);
  always_ff @(posedge clk) begin
    if (rst)         sck <= 1'b0;
    else if (bit_en) sck <= ~sck;
  end

  // Edge about to be generated is rising when sck is low now.
  assign launch = bit_en & (sck == rx_rise);
  assign sample = bit_en & (sck != rx_rise);

  p_sck_holds_r2: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> (sck == $past(sck)));
endmodule

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr #(
  parameter int SAMPLE_W = 16,
  parameter int SLOT_W   = 4,
  localparam int BIT_W   = $clog2(SAMPLE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [SLOT_W-1:0] frame_m1,
  output logic              live,
  output logic [SLOT_W-1:0] cur_slot,
  output logic [BIT_W-1:0]  cur_bit,
  output logic [SLOT_W-1:0] nxt_slot,
  output logic [BIT_W-1:0]  nxt_bit,
  output logic              sync
);
  always_comb begin
    nxt_slot = cur_slot;
    nxt_bit  = cur_bit + 1'b1;
    if (!live) begin
      nxt_slot = '0;
      nxt_bit  = '0;
    end else if (cur_bit == BIT_W'(SAMPLE_W - 1)) begin
      nxt_bit  = '0;
      nxt_slot = (cur_slot == frame_m1) ? '0 : cur_slot + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live     <= 1'b0;
      cur_slot <= '0;
      cur_bit  <= '0;
      sync     <= 1'b0;
    end else if (launch) begin
      live     <= 1'b1;
      cur_slot <= nxt_slot;
      cur_bit  <= nxt_bit;
      // first half of the frame: 2*slot < slots  <=>  2*slot <= slots-1
      sync     <= ({nxt_slot, 1'b0} <= {1'b0, frame_m1});
    end
  end

  p_sync_slot_edge_r3: assert property (@(posedge clk) disable iff (rst)
    (sync != $past(sync)) |-> (cur_bit == '0));
endmodule

// File: rtl/tdm_tx_hold.sv
module tdm_tx_hold #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                take,
  output logic [SAMPLE_W-1:0] word,
  output logic                underrun
);
  logic                full;
  logic [SAMPLE_W-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      full     <= 1'b0;
      hold     <= '0;
      underrun <= 1'b0;
    end else begin
      underrun <= take & ~full;
      if (take) full <= 1'b0;
      if (in_valid && !full) begin
        hold <= in_data;
        full <= 1'b1;
      end
    end
  end

  assign in_ready = ~full;
  assign word     = full ? hold : '0;

  p_hold_kept_r5: assert property (@(posedge clk) disable iff (rst)
    (full && !take) |=> (hold == $past(hold)));
endmodule

// File: rtl/tdm_tx_shift.sv
module tdm_tx_shift #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                launch,
  input  logic                slot_start,
  input  logic [SAMPLE_W-1:0] load_word,
  output logic                txd
);
  logic [SAMPLE_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      txd <= 1'b0;
    end else if (launch) begin
      if (slot_start) begin
        txd <= load_word[SAMPLE_W-1];
        sh  <= {load_word[SAMPLE_W-2:0], 1'b0};
      end else begin
        txd <= sh[SAMPLE_W-1];
        sh  <= {sh[SAMPLE_W-2:0], 1'b0};
      end
    end
  end

  p_txd_on_launch_r2: assert property (@(posedge clk) disable iff (rst)
    (txd != $past(txd)) |-> $past(launch));
endmodule

// File: rtl/tdm_rx_path.sv
module tdm_rx_path
  import tdm_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SLOT_W   = 4,
  localparam int BIT_W   = $clog2(SAMPLE_W)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           sample,
  input  logic                           live,
  input  logic                           rxd,
  input  logic [SLOT_W-1:0]              cur_slot,
  input  logic [BIT_W-1:0]               cur_bit,
  input  logic [NUM_CH-1:0]              ch_en,
  input  logic [NUM_CH-1:0][SLOT_W-1:0]  ch_slot,
  output logic [NUM_CH-1:0][SAMPLE_W-1:0] out_data,
  output logic [NUM_CH-1:0]              out_valid
);
  logic [SAMPLE_W-1:0] sh;
  logic [SAMPLE_W-1:0] word;
  logic                last_bit;

  assign word     = {sh[SAMPLE_W-2:0], rxd};
  assign last_bit = sample & live & (cur_bit == BIT_W'(SAMPLE_W - 1));

  always_ff @(posedge clk) begin
    if (rst)                 sh <= '0;
    else if (sample && live) sh <= word;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cap
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid[i] <= 1'b0;
        out_data[i]  <= '0;
      end else begin
        out_valid[i] <= 1'b0;
        if (last_bit && ch_en[i] && (ch_slot[i] == cur_slot)) begin
          out_data[i]  <= word;
          out_valid[i] <= 1'b1;
        end
      end
    end

    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      out_valid[i] |=> !out_valid[i]);
  end
endmodule

// File: rtl/tdm_audio_port.sv
module tdm_audio_port
  import tdm_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SLOT_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_en,
  input  logic                cfg_rx_rise,
  input  logic [SLOT_W-1:0]   cfg_frame_slots_m1,
  input  logic                tx_l_en,
  input  logic [SLOT_W-1:0]   tx_l_slot,
  input  logic                tx_r_en,
  input  logic [SLOT_W-1:0]   tx_r_slot,
  input  logic                rx_l_en,
  input  logic [SLOT_W-1:0]   rx_l_slot,
  input  logic                rx_r_en,
  input  logic [SLOT_W-1:0]   rx_r_slot,
  input  logic [SAMPLE_W-1:0] tx_l_data,
  input  logic                tx_l_valid,
  output logic                tx_l_ready,
  input  logic [SAMPLE_W-1:0] tx_r_data,
  input  logic                tx_r_valid,
  output logic                tx_r_ready,
  input  logic                rxd,
  output logic                tx_l_underrun,
  output logic                tx_r_underrun,
  output logic [SAMPLE_W-1:0] rx_l_data,
  output logic                rx_l_valid,
  output logic [SAMPLE_W-1:0] rx_r_data,
  output logic                rx_r_valid,
  output logic                sck,
  output logic                sync,
  output logic                txd
);
  localparam int BIT_W = $clog2(SAMPLE_W);

  logic              launch, sample, live;
  logic [SLOT_W-1:0] cur_slot, nxt_slot;
  logic [BIT_W-1:0]  cur_bit, nxt_bit;

  tdm_sck_gen u_sck (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_rise(cfg_rx_rise),
    .sck(sck), .launch(launch), .sample(sample)
  );

  tdm_frame_ctr #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_frame (
    .clk(clk), .rst(rst), .launch(launch), .frame_m1(cfg_frame_slots_m1),
    .live(live), .cur_slot(cur_slot), .cur_bit(cur_bit),
    .nxt_slot(nxt_slot), .nxt_bit(nxt_bit), .sync(sync)
  );

  // Transmit channels: holding registers and slot ownership
  logic [NUM_CH-1:0]               tx_en, tx_valid, tx_ready, tx_take, tx_hit, tx_ur;
  logic [NUM_CH-1:0][SLOT_W-1:0]   tx_slot;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] tx_in, tx_word;
  logic                            slot_start;
  logic [SAMPLE_W-1:0]             load_word;

  assign tx_en    = {tx_r_en, tx_l_en};
  assign tx_slot  = {tx_r_slot, tx_l_slot};
  assign tx_valid = {tx_r_valid, tx_l_valid};
  assign tx_in    = {tx_r_data, tx_l_data};
  assign slot_start = launch & (nxt_bit == '0);

  // Left owns a slot that both channels name
  assign tx_hit[CH_L] = tx_en[CH_L] & (tx_slot[CH_L] == nxt_slot);
  assign tx_hit[CH_R] = tx_en[CH_R] & (tx_slot[CH_R] == nxt_slot) & ~tx_hit[CH_L];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_tx
    assign tx_take[i] = slot_start & tx_hit[i];
    tdm_tx_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
      .clk(clk), .rst(rst), .in_data(tx_in[i]), .in_valid(tx_valid[i]),
      .in_ready(tx_ready[i]), .take(tx_take[i]), .word(tx_word[i]),
      .underrun(tx_ur[i])
    );
  end

  always_comb begin
    load_word = '0;
    if (tx_hit[CH_L])      load_word = tx_word[CH_L];
    else if (tx_hit[CH_R]) load_word = tx_word[CH_R];
  end

  assign tx_l_ready    = tx_ready[CH_L];
  assign tx_r_ready    = tx_ready[CH_R];
  assign tx_l_underrun = tx_ur[CH_L];
  assign tx_r_underrun = tx_ur[CH_R];

  tdm_tx_shift #(.SAMPLE_W(SAMPLE_W)) u_txsh (
    .clk(clk), .rst(rst), .launch(launch), .slot_start(slot_start),
    .load_word(load_word), .txd(txd)
  );

  // Receive channels
  logic [NUM_CH-1:0][SAMPLE_W-1:0] rx_data;
  logic [NUM_CH-1:0]               rx_valid;

  tdm_rx_path #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_rx (
    .clk(clk), .rst(rst), .sample(sample), .live(live), .rxd(rxd),
    .cur_slot(cur_slot), .cur_bit(cur_bit),
    .ch_en({rx_r_en, rx_l_en}), .ch_slot({rx_r_slot, rx_l_slot}),
    .out_data(rx_data), .out_valid(rx_valid)
  );

  assign rx_l_data  = rx_data[CH_L];
  assign rx_r_data  = rx_data[CH_R];
  assign rx_l_valid = rx_valid[CH_L];
  assign rx_r_valid = rx_valid[CH_R];

  p_left_wins_r9: assert property (@(posedge clk) disable iff (rst)
    !(tx_take[CH_L] && tx_take[CH_R]));
endmodule

// File: tb/tdm_audio_port_tb.sv
module tdm_audio_port_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1, bit_en = 1'b0, cfg_rx_rise = 1'b1;
  logic [3:0]  cfg_frame_slots_m1 = 4'd1;
  logic        tx_l_en = 0, tx_r_en = 0, rx_l_en = 0, rx_r_en = 0;
  logic [3:0]  tx_l_slot = 0, tx_r_slot = 0, rx_l_slot = 0, rx_r_slot = 0;
  logic [15:0] tx_l_data = 0, tx_r_data = 0;
  logic        tx_l_valid = 0, tx_r_valid = 0, rxd = 0;
  logic        tx_l_ready, tx_r_ready, tx_l_underrun, tx_r_underrun;
  logic [15:0] rx_l_data, rx_r_data;
  logic        rx_l_valid, rx_r_valid, sck, sync, txd;

  tdm_audio_port dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .cfg_rx_rise(cfg_rx_rise),
    .cfg_frame_slots_m1(cfg_frame_slots_m1),
    .tx_l_en(tx_l_en), .tx_l_slot(tx_l_slot), .tx_r_en(tx_r_en), .tx_r_slot(tx_r_slot),
    .rx_l_en(rx_l_en), .rx_l_slot(rx_l_slot), .rx_r_en(rx_r_en), .rx_r_slot(rx_r_slot),
    .tx_l_data(tx_l_data), .tx_l_valid(tx_l_valid), .tx_l_ready(tx_l_ready),
    .tx_r_data(tx_r_data), .tx_r_valid(tx_r_valid), .tx_r_ready(tx_r_ready),
    .rxd(rxd), .tx_l_underrun(tx_l_underrun), .tx_r_underrun(tx_r_underrun),
    .rx_l_data(rx_l_data), .rx_l_valid(rx_l_valid),
    .rx_r_data(rx_r_data), .rx_r_valid(rx_r_valid),
    .sck(sck), .sync(sync), .txd(txd)
  );

  int n_run = 0, n_fail = 0;
  logic       cap_tx [0:127];
  logic       cap_sy [0:127];
  logic       rx_bits[0:127];
  int         nb, edge_err, lv_n, rv_n, ul_n, ur_n;
  logic [15:0] lv_first, rv_first;
  logic       prev_sck, last_tx, last_sy;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] cap_word(int base);
    logic [15:0] w;
    for (int k = 0; k < 16; k++) w[15-k] = cap_tx[base+k];
    return w;
  endfunction

  task automatic put_rx(int slot, logic [15:0] w);
    for (int k = 0; k < 16; k++) rx_bits[slot*16+k] = w[15-k];
  endtask

  task automatic tick();
    @(negedge clk);
    if (sck !== prev_sck && sck === ~cfg_rx_rise) begin
      if (nb < 128) begin
        cap_tx[nb] = txd; cap_sy[nb] = sync; rxd = rx_bits[nb];
      end
      last_tx = txd; last_sy = sync; nb++;
    end else if (nb > 0 && (txd !== last_tx || sync !== last_sy)) begin
      edge_err++;
    end
    prev_sck = sck;
    if (rx_l_valid) begin if (lv_n == 0) lv_first = rx_l_data; lv_n++; end
    if (rx_r_valid) begin if (rv_n == 0) rv_first = rx_r_data; rv_n++; end
    if (tx_l_underrun) ul_n++;
    if (tx_r_underrun) ur_n++;
  endtask

  task automatic restart(logic rise, logic [3:0] m1);
    @(negedge clk);
    rst = 1'b1; bit_en = 1'b0; cfg_rx_rise = rise; cfg_frame_slots_m1 = m1;
    tx_l_valid = 0; tx_r_valid = 0; rxd = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    nb = 0; edge_err = 0; lv_n = 0; rv_n = 0; ul_n = 0; ur_n = 0;
    lv_first = 0; rv_first = 0; prev_sck = 1'b0; last_tx = 0; last_sy = 0;
    for (int k = 0; k < 128; k++) begin rx_bits[k] = 0; cap_tx[k] = 0; cap_sy[k] = 0; end
  endtask

  task automatic load(logic right, logic [15:0] w);
    @(negedge clk);
    if (right) begin tx_r_data = w; tx_r_valid = 1; end
    else       begin tx_l_data = w; tx_l_valid = 1; end
    @(negedge clk);
    tx_l_valid = 0; tx_r_valid = 0;
  endtask

  task automatic run_bits(int n);
    bit_en = 1'b1;
    while (nb < n) tick();
    tick();              // sample edge of the last bit
    bit_en = 1'b0;
    tick(); tick();
  endtask

  task automatic check_sync(int n, int flen);
    int bad = 0;
    for (int k = 0; k < n; k++)
      if (cap_sy[k] !== ((k % flen) < flen/2)) bad++;
    chk("R3", "sync mismatches", bad, 0);
  endtask

  task automatic t_reset();
    restart(1'b1, 4'd1);
    repeat (2) @(negedge clk);
    chk("R1", "sck/sync/txd", {sck, sync, txd}, 3'b000);
    chk("R1", "tx ready", {tx_l_ready, tx_r_ready}, 2'b11);
    chk("R1", "rx valid/underrun", {rx_l_valid, rx_r_valid, tx_l_underrun, tx_r_underrun}, 4'b0);
  endtask

  task automatic t_stereo32();
    restart(1'b1, 4'd1);
    tx_l_en = 1; tx_l_slot = 0; tx_r_en = 1; tx_r_slot = 1;
    rx_l_en = 1; rx_l_slot = 0; rx_r_en = 1; rx_r_slot = 1;
    put_rx(0, 16'hBEEF); put_rx(1, 16'h0F0F);
    load(1'b0, 16'hA5C3); load(1'b1, 16'h1234);
    chk("R5", "ready after load", {tx_l_ready, tx_r_ready}, 2'b00);
    run_bits(64);
    chk("R4", "slot0 word", cap_word(0), 16'hA5C3);
    chk("R4", "slot1 word", cap_word(16), 16'h1234);
    chk("R6", "frame1 words", {cap_word(32), cap_word(48)}, 32'h0);
    chk("R6", "underrun pulses L/R", {ul_n[7:0], ur_n[7:0]}, 16'h0101);
    chk("R5", "ready after slot", {tx_l_ready, tx_r_ready}, 2'b11);
    check_sync(64, 32);
    chk("R2", "rising-edge sample L", lv_first, 16'hBEEF);
    chk("R7", "rx right word", rv_first, 16'h0F0F);
    chk("R7", "rx valid counts", {lv_n[7:0], rv_n[7:0]}, 16'h0202);
    chk("R2", "txd/sync moved off launch edge", edge_err, 0);
  endtask

  task automatic t_map64();
    restart(1'b0, 4'd3);
    tx_l_en = 1; tx_l_slot = 0; rx_l_en = 1; rx_l_slot = 1;
    tx_r_en = 1; tx_r_slot = 2; rx_r_en = 1; rx_r_slot = 3;
    put_rx(0, 16'h1111); put_rx(1, 16'hABCD); put_rx(2, 16'h2222); put_rx(3, 16'h5AA5);
    load(1'b0, 16'hC0DE); load(1'b1, 16'h7E57);
    run_bits(64);
    chk("R10", "tx slots 0..3", {cap_word(0), cap_word(16), cap_word(32), cap_word(48)},
        {16'hC0DE, 16'h0000, 16'h7E57, 16'h0000});
    check_sync(64, 64);
    chk("R10", "rx left from slot1", lv_first, 16'hABCD);
    chk("R2", "falling-edge sample R", rv_first, 16'h5AA5);
    chk("R6", "no underrun", {ul_n[7:0], ur_n[7:0]}, 16'h0);
    chk("R2", "txd/sync moved off launch edge (fall)", edge_err, 0);
  endtask

  task automatic t_shared_slot();
    restart(1'b1, 4'd1);
    tx_l_en = 1; tx_l_slot = 0; tx_r_en = 1; tx_r_slot = 0;
    rx_l_en = 1; rx_l_slot = 1; rx_r_en = 0; rx_r_slot = 1;
    put_rx(1, 16'h6C6C);
    load(1'b0, 16'h1357); load(1'b1, 16'h9BDF);
    run_bits(32);
    chk("R9", "left drives shared slot", cap_word(0), 16'h1357);
    chk("R4", "unowned slot1 low", cap_word(16), 16'h0);
    chk("R9", "right word kept", tx_r_ready, 1'b0);
    chk("R9", "right no underrun", ur_n, 0);
    chk("R8", "disabled rx right silent", rv_n, 0);
    chk("R7", "rx left slot1", {lv_n[7:0], lv_first}, {8'd1, 16'h6C6C});
  endtask

  task automatic t_disabled_tx();
    restart(1'b1, 4'd1);
    tx_l_en = 1; tx_l_slot = 0; tx_r_en = 0; tx_r_slot = 1;
    rx_l_en = 0; rx_r_en = 0;
    load(1'b1, 16'hFFFF);
    run_bits(32);
    chk("R6", "empty left slot zero", cap_word(0), 16'h0);
    chk("R6", "left underrun once", ul_n, 1);
    chk("R8", "disabled right slot low", cap_word(16), 16'h0);
    chk("R8", "disabled right keeps word", {tx_r_ready, ur_n[0]}, 2'b00);
  endtask

  initial begin
    t_reset();
    t_stereo32();
    t_map64();
    t_shared_slot();
    t_disabled_tx();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule